// File: doc/BRIEF.md
# Pipeline Error-Rate Monitor

This block watches the per-cycle timing-error flag of one floating-point pipeline and turns it into a rate. The rate is the share of observed cycles that carried an error, written as a whole percentage. Counting runs over a sampling window whose length, in counted cycles, software sets through a period register. When a window closes, the block latches the percentage into a readable result register and raises a one-cycle done flag. Both internal counters then clear, and the next window starts on the following cycle, so characterisation goes on for as long as the pipeline runs.

Each pipeline that needs a rate gets its own instance. The result register keeps its value between window ends, so a reader always sees the most recently completed measurement. An enable input pauses counting without losing the partial window. Writing the period register throws away the partial window and starts a fresh one. A period written as zero behaves as a one-cycle window.

Top module: `pipe_err_rate_mon`

## Requirements
- R1: After reset, rate_pct is 0 and win_done is 0. The period register holds PERIOD_RST (16 by default), so the first window closes after 16 enabled cycles with no write.
- R2: A window covers exactly P enabled cycles, where P is the period register value. win_done is 1 for the single cycle that follows the clock edge that counts the P-th cycle, and it is 0 after the earlier cycles of that window.
- R3: When a window closes, rate_pct becomes floor(100 × E / P), where E is the number of counted cycles in that window that had err_evt = 1.
- R4: rate_pct changes only on the cycle where win_done is 1. Between window ends it holds its value.
- R5: rate_pct never exceeds 100.
- R6: Both counts clear at a window boundary. The next window starts on the next enabled cycle and carries nothing over from the window before.
- R7: A period register value of 0 is treated as 1. Every enabled cycle then closes a window, and the rate is 100 when the error flag is 1 and 0 when it is 0.
- R8: A cycle with period_wr = 1 stores period_wdata and restarts the window. That cycle is not counted, err_evt in that cycle is ignored, and win_done is 0 on the next cycle.
- R9: A cycle with enable = 0 is not counted. err_evt in that cycle is ignored, and win_done is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counts this cycle when 1 |
| err_evt | input | 1 | Timing error flagged by the sensors in this cycle |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | CNT_W | New sampling period, in counted cycles |
| rate_pct | output | 7 | Error-cycle percentage of the last completed window, 0 to 100 |
| win_done | output | 1 | One-cycle pulse when a window has closed |

## Verification
The assertions assume that rst_n is low from time zero until the first edges have passed, and that enable, err_evt and period_wr always hold known values. They also assume that period_wdata fits CNT_W, so the period register holds what software meant to write. The bench sets every input one time unit after a rising edge and keeps it there for the whole cycle. It starts with reset asserted and every control input at 0, and it only writes periods that are far below the counter range. Error flags are placed at the start of each window, so the expected error count of every window is exact.

// File: rtl/pipe_err_pkg.sv
package pipe_err_pkg;
   localparam int PCT_W    = 7;
   localparam int PCT_FULL = 100;
   typedef logic [PCT_W-1:0] pct_t;
endpackage

// File: rtl/pipe_err_period_reg.sv
// Period register: stores the window length, clamps zero to one,
// and signals a restart on every write.
module pipe_err_period_reg #(
   parameter int CNT_W      = 16,
   parameter int PERIOD_RST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] eff_period,
   output logic             restart
);
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(PERIOD_RST);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] per_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  per_q <= RST_VAL;
      else if (wr) per_q <= wdata;
   end

   assign eff_period = (per_q == '0) ? ONE : per_q;
   assign restart    = wr;
endmodule

// File: rtl/pipe_err_win_ctr.sv
// Window counters: count enabled cycles and the error cycles among them,
// and flag the cycle that closes the window.
module pipe_err_win_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             err_evt,
   input  logic             restart,
   input  logic [CNT_W-1:0] eff_period,
   output logic             close,
   output logic [CNT_W-1:0] err_total
);
   logic [CNT_W-1:0] cyc_q, err_q, cyc_nx, err_nx;

   always_comb begin
      cyc_nx = cyc_q + CNT_W'(1);
      err_nx = err_q + CNT_W'(err_evt);
   end

   assign close     = enable && !restart && (cyc_nx == eff_period);
   assign err_total = err_nx;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cyc_q <= '0;
         err_q <= '0;
      end else if (enable) begin
         if (close) begin
            cyc_q <= '0;
            err_q <= '0;
         end else begin
            cyc_q <= cyc_nx;
            err_q <= err_nx;
         end
      end
   end
endmodule

// File: rtl/pipe_err_pct_div.sv
// Percentage divider: floor(100*num/den). The quotient never exceeds
// 100, so it fits PCT_W bits. DIV_STYLE 0 builds an unrolled
// restoring divider; DIV_STYLE 1 uses the division operator.
module pipe_err_pct_div
   import pipe_err_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DIV_STYLE = 0
) (
   input  logic [CNT_W-1:0] num,
   input  logic [CNT_W-1:0] den,
   output pct_t             pct
);
   localparam int DW = CNT_W + PCT_W;

   logic [DW-1:0] scaled;
   assign scaled = DW'(num) * DW'(PCT_FULL);

   if (DIV_STYLE == 0) begin : g_restoring
      logic [DW-1:0] rem [1:PCT_W];
      assign rem[PCT_W] = scaled;
      for (genvar g = PCT_W-1; g >= 0; g--) begin : g_stage
         logic [DW-1:0] trial;
         assign trial  = DW'(den) << g;
         assign pct[g] = (rem[g+1] >= trial);
         if (g > 0) begin : g_rem
            assign rem[g] = pct[g] ? (rem[g+1] - trial) : rem[g+1];
         end
      end
   end else begin : g_operator
      logic [DW-1:0] quo;
      assign quo = scaled / DW'(den);
      assign pct = quo[PCT_W-1:0];
   end
endmodule

// File: rtl/pipe_err_rate_mon.sv
module pipe_err_rate_mon
   import pipe_err_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int PERIOD_RST = 16,
   parameter int DIV_STYLE  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             err_evt,
   input  logic             period_wr,
   input  logic [CNT_W-1:0] period_wdata,
   output logic [6:0]       rate_pct,
   output logic             win_done
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pipe_err_rate_mon: CNT_W out of range");
   end
   if (PERIOD_RST < 0 || PERIOD_RST >= (2 ** CNT_W)) begin : g_bad_rst
      $error("pipe_err_rate_mon: PERIOD_RST does not fit CNT_W");
   end
   if (DIV_STYLE != 0 && DIV_STYLE != 1) begin : g_bad_style
      $error("pipe_err_rate_mon: DIV_STYLE must be 0 or 1");
   end

   logic [CNT_W-1:0] eff_period, err_total;
   logic             restart, close;
   pct_t             pct_nx, rate_q;
   logic             done_q;

   pipe_err_period_reg #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_per (
      .clk(clk), .rst_n(rst_n), .wr(period_wr), .wdata(period_wdata),
      .eff_period(eff_period), .restart(restart));

   pipe_err_win_ctr #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .enable(enable), .err_evt(err_evt),
      .restart(restart), .eff_period(eff_period),
      .close(close), .err_total(err_total));

   pipe_err_pct_div #(.CNT_W(CNT_W), .DIV_STYLE(DIV_STYLE)) u_div (
      .num(err_total), .den(eff_period), .pct(pct_nx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= close;
         if (close) rate_q <= pct_nx;
      end
   end

   assign rate_pct = rate_q;
   assign win_done = done_q;
endmodule

// File: rtl/pipe_err_rate_mon_chk.sv
module pipe_err_rate_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       period_wr,
   input logic [6:0] rate_pct,
   input logic       win_done
);
   AST_PCT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rate_pct <= 7'd100); // R5
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !win_done |-> $stable(rate_pct)); // R4
   AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      period_wr |=> !win_done); // R8
   AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !win_done); // R9
endmodule

bind pipe_err_rate_mon pipe_err_rate_mon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .period_wr(period_wr),
   .rate_pct(rate_pct), .win_done(win_done));

// File: tb/pipe_err_rate_mon_test.sv
module pipe_err_rate_mon_test;
   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int NVEC  = 12;
   // per, errors, expected percent
   localparam logic [39:0] VEC [NVEC] = '{
      {16'd10,  16'd3,   8'd30},
      {16'd7,   16'd1,   8'd14},
      {16'd3,   16'd2,   8'd66},
      {16'd100, 16'd100, 8'd100},
      {16'd50,  16'd0,   8'd0},
      {16'd13,  16'd13,  8'd100},
      {16'd200, 16'd1,   8'd0},
      {16'd6,   16'd5,   8'd83},
      {16'd0,   16'd0,   8'd0},
      {16'd0,   16'd1,   8'd100},
      {16'd1,   16'd1,   8'd100},
      {16'd9,   16'd4,   8'd44}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          err_evt = 1'b0;
   logic          period_wr = 1'b0;
   logic [CW-1:0] period_wdata = '0;
   logic [6:0]    rate_pct;
   logic          win_done;
   int            n_chk = 0;
   int            n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   pipe_err_rate_mon #(.CNT_W(CW), .PERIOD_RST(16), .DIV_STYLE(0)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .err_evt(err_evt),
      .period_wr(period_wr), .period_wdata(period_wdata),
      .rate_pct(rate_pct), .win_done(win_done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // inputs set 1 time unit after an edge; outputs read there too
   task automatic cyc(input bit en, input bit er, input bit wr, input int wd);
      enable = en; err_evt = er; period_wr = wr; period_wdata = CW'(wd);
      @(posedge clk); #1;
      period_wr = 1'b0;
   endtask

   task automatic window(input int per, input int ne, input int exp, input string req);
      int pe;
      pe = (per == 0) ? 1 : per;
      cyc(1'b0, 1'b0, 1'b1, per);
      chk(win_done == 1'b0, "R8", win_done, 0);
      for (int c = 0; c < pe; c++) begin
         cyc(1'b1, c < ne, 1'b0, 0);
         if (c == pe - 2) chk(win_done == 1'b0, "R2", win_done, 0);
      end
      chk(win_done == 1'b1, "R2", win_done, 1);
      chk(rate_pct == 7'(exp), req, rate_pct, exp);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(rate_pct == 7'd0, "R1", rate_pct, 0);
      chk(win_done == 1'b0, "R1", win_done, 0);
      rst_n = 1'b1;
      // R1: default period 16, 8 error cycles -> 50
      for (int c = 0; c < 16; c++) begin
         cyc(1'b1, c < 8, 1'b0, 0);
         if (c == 14) chk(win_done == 1'b0, "R1", win_done, 0);
      end
      chk(win_done == 1'b1, "R1", win_done, 1);
      chk(rate_pct == 7'd50, "R1", rate_pct, 50);

      // vector table: R3, R5, R7
      for (int i = 0; i < NVEC; i++) begin
         window(int'(VEC[i][39:24]), int'(VEC[i][23:8]), int'(VEC[i][7:0]),
                (VEC[i][39:24] == 0) ? "R7" : "R3");
         chk(rate_pct <= 7'd100, "R5", rate_pct, 100);
      end

      // R4: partial window keeps the published value
      window(5, 1, 20, "R3");
      for (int c = 0; c < 3; c++) begin
         cyc(1'b1, 1'b1, 1'b0, 0);
         chk(rate_pct == 7'd20, "R4", rate_pct, 20);
         chk(win_done == 1'b0, "R4", win_done, 0);
      end

      // R9: paused cycles with errors are not counted
      cyc(1'b0, 1'b0, 1'b1, 4);
      cyc(1'b1, 1'b1, 1'b0, 0);
      cyc(1'b1, 1'b1, 1'b0, 0);
      for (int c = 0; c < 3; c++) begin
         cyc(1'b0, 1'b1, 1'b0, 0);
         chk(win_done == 1'b0, "R9", win_done, 0);
      end
      cyc(1'b1, 1'b0, 1'b0, 0);
      chk(win_done == 1'b0, "R9", win_done, 0);
      cyc(1'b1, 1'b0, 1'b0, 0);
      chk(win_done == 1'b1, "R9", win_done, 1);
      chk(rate_pct == 7'd50, "R9", rate_pct, 50);

      // R8: write mid-window restarts; error in the write cycle ignored
      cyc(1'b0, 1'b0, 1'b1, 5);
      for (int c = 0; c < 3; c++) cyc(1'b1, 1'b1, 1'b0, 0);
      cyc(1'b1, 1'b1, 1'b1, 5);
      chk(win_done == 1'b0, "R8", win_done, 0);
      for (int c = 0; c < 5; c++) begin
         cyc(1'b1, 1'b0, 1'b0, 0);
         if (c == 3) chk(win_done == 1'b0, "R8", win_done, 0);
      end
      chk(win_done == 1'b1, "R8", win_done, 1);
      chk(rate_pct == 7'd0, "R8", rate_pct, 0);

      // R6: back-to-back windows, nothing carried over
      cyc(1'b0, 1'b0, 1'b1, 4);
      for (int c = 0; c < 4; c++) cyc(1'b1, 1'b1, 1'b0, 0);
      chk(win_done == 1'b1, "R6", win_done, 1);
      chk(rate_pct == 7'd100, "R6", rate_pct, 100);
      for (int c = 0; c < 4; c++) begin
         cyc(1'b1, c == 0, 1'b0, 0);
         if (c == 0) chk(win_done == 1'b0, "R6", win_done, 0);
      end
      chk(win_done == 1'b1, "R6", win_done, 1);
      chk(rate_pct == 7'd25, "R6", rate_pct, 25);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule